// File: doc/BRIEF.md
# Cache Tag Store with Equality Comparator

This block holds one tag per line of a direct-mapped cache and tells the cache controller whether a presented tag hits. On every clock it samples three active-low controls, a line address and an 8-bit tag. Depending on the controls it does one of four things: stays idle, stores the tag at the addressed line, drives the stored tag out, or compares the presented tag against the stored one. The compare result goes out on a single `match` flag.

`match` is released (high) in every mode other than compare. Several stores can therefore be combined by a plain AND, which acts as a wired-AND bus: one pulled-low flag marks a miss for the whole group. With 13 line bits and 7 page bits a 1 MB space maps onto 8K lines. In that arrangement the tag holds the page bits and its top bit stays unused.

An active-low reset invalidates every line in a single cycle. A line not written since reset reads as 0x00 and compares as 0x00. The line count is set by `LINE_W`. The default is 10 (1024 lines), and an 8K-line store uses `LINE_W = 13`.

Top module: `tag_store_cmp`

## Requirements
- R1: A clock edge that samples `rst_n` low leaves `match` = 1, `rd_drive` = 0 and `rd_tag` = 0 after it. Afterwards every line holds 0x00.
- R2: While `rst_n` is low, all other inputs are ignored. A write presented during reset does not change any line.
- R3: `ce_n` = 1 is standby. `match` = 1, `rd_drive` = 0 and `rd_tag` = 0, and no line changes, whatever `we_n` is.
- R4: `ce_n` = 0 with `we_n` = 0 stores `tag_in` at `line_addr`. This holds for the lowest and highest lines. `match` = 1 and `rd_drive` = 0 in that cycle.
- R5: `ce_n` = 0, `we_n` = 1, `oe_n` = 0 is a read. `rd_tag` shows the stored tag and `rd_drive` = 1. `match` is forced to 1 even when `tag_in` differs from the stored tag.
- R6: `ce_n` = 0, `we_n` = 1, `oe_n` = 1 is a compare. `match` = 1 exactly when `tag_in` equals the stored tag at `line_addr`, and `rd_drive` = 0.
- R7: All outputs are registered. They show the operation sampled at the previous rising edge. A compare or read on the cycle right after a write to the same line sees the newly written tag.
- R8: A line not written since reset reads 0x00. A compare against 0x00 on that line gives `match` = 1, and any other value gives 0.
- R9: Whenever `rd_drive` = 0, `rd_tag` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset; invalidates all lines |
| ce_n | input | 1 | Active-low chip enable |
| we_n | input | 1 | Active-low write enable |
| oe_n | input | 1 | Active-low output enable (read when low, compare when high) |
| line_addr | input | LINE_W | Line index |
| tag_in | input | TAG_W | Tag to store or to compare |
| rd_tag | output | TAG_W | Stored tag of the last read, else 0 |
| rd_drive | output | 1 | High when `rd_tag` carries read data |
| match | output | 1 | Compare result; high in every non-compare mode |

## Verification
The hardest state to reach is a reset that arrives while a write is presented. If the invalidation were not strictly prioritised, the write would leave a valid line behind. The stimulus holds `we_n` low on a fresh line through a reset edge, then reads that line and a previously written one. It also places a write and a compare to the same line on back-to-back edges, and it drives a compare with a mismatching tag while `oe_n` is low, to show the read-mode override. A long random run over a narrow address window makes reads, writes and compares collide on the same few lines.

// File: rtl/tag_pkg.sv
// Package: shared mode type and decode for the tag store.
// Assumes the three controls are active low and sampled on the same edge.
package tag_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE  = 2'd0,
        MODE_WRITE = 2'd1,
        MODE_READ  = 2'd2,
        MODE_CMP   = 2'd3
    } tag_mode_e;

    // Map the active-low controls onto one operating mode.
    function automatic tag_mode_e decode_mode(input logic ce_n,
                                              input logic we_n,
                                              input logic oe_n);
        tag_mode_e m;
        if (ce_n)      m = MODE_IDLE;
        else if (!we_n) m = MODE_WRITE;
        else if (!oe_n) m = MODE_READ;
        else           m = MODE_CMP;
        return m;
    endfunction

endpackage

// File: rtl/tag_mode_dec.sv
// Module: tag_mode_dec
// Turns the chip, write and output enables into one mode code and a write
// strobe. Assumes reset gating is applied downstream (array and output stage).
module tag_mode_dec
    import tag_pkg::*;
(
    input  logic      ce_n,
    input  logic      we_n,
    input  logic      oe_n,
    output tag_mode_e mode,
    output logic      wr_req
);

    // Decode the operating mode for this cycle.
    always_comb begin
        mode   = decode_mode(ce_n, we_n, oe_n);
        wr_req = (mode == MODE_WRITE);
    end

endmodule

// File: rtl/tag_array.sv
// Module: tag_array
// Tag storage with a per-line valid bitmap. The bitmap is cleared in one
// cycle by reset, so invalid lines read as zero without touching the data
// words. Assumes a single write or read per cycle; read is combinational.
module tag_array #(
    parameter int LINE_W = 10,
    parameter int TAG_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [LINE_W-1:0] addr,
    input  logic [TAG_W-1:0]  wdata,
    output logic [TAG_W-1:0]  rdata
);

    localparam int LINES = 1 << LINE_W;

    logic [TAG_W-1:0] words [LINES];
    logic [LINES-1:0] valid;

    // Store the tag word; data words need no reset since valid gates them.
    always_ff @(posedge clk) begin
        if (rst_n && wr_en)
            words[addr] <= wdata;
    end

    // Track which lines hold a tag written since the last reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            valid <= '0;
        else if (wr_en)
            valid[addr] <= 1'b1;
    end

    // Present the stored tag, or zero for a line never written.
    always_comb begin
        rdata = valid[addr] ? words[addr] : '0;
    end

    // R1
    flash_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (valid == '0));

    // R4
    write_marks_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> valid[$past(addr)]);

    // R2
    reset_blocks_write_chk: assert property (@(posedge clk)
        (!rst_n && wr_en) |=> (valid == '0));

endmodule

// File: rtl/tag_out_stage.sv
// Module: tag_out_stage
// Registers the compare flag and read data one clock after the operation is
// sampled. Every non-compare mode releases the flag high so several stores
// can be ANDed. Assumes 'stored' is the tag at the address sampled this cycle.
module tag_out_stage
    import tag_pkg::*;
#(
    parameter int TAG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  tag_mode_e        mode,
    input  logic [TAG_W-1:0] stored,
    input  logic [TAG_W-1:0] tag_in,
    output logic             match,
    output logic             rd_drive,
    output logic [TAG_W-1:0] rd_tag
);

    logic hit;

    // Equality of the presented tag with the stored one.
    always_comb begin
        hit = (stored == tag_in);
    end

    // Update flag and read data together on each edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match    <= 1'b1;
            rd_drive <= 1'b0;
            rd_tag   <= '0;
        end else begin
            unique case (mode)
                MODE_CMP: begin
                    match    <= hit;
                    rd_drive <= 1'b0;
                    rd_tag   <= '0;
                end
                MODE_READ: begin
                    match    <= 1'b1;
                    rd_drive <= 1'b1;
                    rd_tag   <= stored;
                end
                default: begin
                    match    <= 1'b1;
                    rd_drive <= 1'b0;
                    rd_tag   <= '0;
                end
            endcase
        end
    end

    // R1
    reset_release_chk: assert property (@(posedge clk)
        !rst_n |=> (match && !rd_drive));

    // R3
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_IDLE) |=> (match && !rd_drive));

    // R4
    write_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_WRITE) |=> (match && !rd_drive));

    // R5
    read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_READ) |=> (rd_drive && match && rd_tag == $past(stored)));

    // R6
    miss_pulls_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_CMP && stored != tag_in) |=> !match);

    // R9
    quiet_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_drive |-> (rd_tag == '0));

endmodule

// File: rtl/tag_store_cmp.sv
// Module: tag_store_cmp (top)
// Direct-mapped cache tag store: write, read, compare and one-cycle clear.
// Assumes synchronous use; all outputs change one clock after the inputs
// are sampled. The top tag bit is spare when only page bits are stored.
module tag_store_cmp
    import tag_pkg::*;
#(
    parameter int LINE_W = 10,
    parameter int TAG_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [LINE_W-1:0] line_addr,
    input  logic [TAG_W-1:0]  tag_in,
    output logic [TAG_W-1:0]  rd_tag,
    output logic              rd_drive,
    output logic              match
);

    tag_mode_e        mode;
    logic             wr_req;
    logic [TAG_W-1:0] stored;

    tag_mode_dec u_dec (
        .ce_n   (ce_n),
        .we_n   (we_n),
        .oe_n   (oe_n),
        .mode   (mode),
        .wr_req (wr_req)
    );

    tag_array #(.LINE_W(LINE_W), .TAG_W(TAG_W)) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_req),
        .addr  (line_addr),
        .wdata (tag_in),
        .rdata (stored)
    );

    tag_out_stage #(.TAG_W(TAG_W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .stored   (stored),
        .tag_in   (tag_in),
        .match    (match),
        .rd_drive (rd_drive),
        .rd_tag   (rd_tag)
    );

    // R7
    write_then_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !we_n) ##1 (!ce_n && we_n && oe_n &&
                              line_addr == $past(line_addr) &&
                              tag_in == $past(tag_in)) |=> match);

endmodule

// File: tb/sim_tag_store_cmp.sv
module sim_tag_store_cmp;

    localparam int LW = 10;
    localparam int TW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1;
    logic          we_n = 1'b1;
    logic          oe_n = 1'b1;
    logic [LW-1:0] line_addr = '0;
    logic [TW-1:0] tag_in = '0;
    logic [TW-1:0] rd_tag;
    logic          rd_drive;
    logic          match;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    bit [TW-1:0] ref_mem [int];

    always #4 clk = ~clk;

    tag_store_cmp #(.LINE_W(LW), .TAG_W(TW)) u0 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .line_addr(line_addr), .tag_in(tag_in),
        .rd_tag(rd_tag), .rd_drive(rd_drive), .match(match)
    );

    task automatic step(input logic r, input logic c, input logic w,
                        input logic o, input logic [LW-1:0] a,
                        input logic [TW-1:0] t, input string req);
        logic          em, ed;
        logic [TW-1:0] et, st;
        @(negedge clk);
        rst_n = r; ce_n = c; we_n = w; oe_n = o; line_addr = a; tag_in = t;
        st = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : '0;
        em = 1'b1; ed = 1'b0; et = '0;
        if (!r)          ref_mem.delete();
        else if (c)      ;
        else if (!w)     ref_mem[int'(a)] = t;
        else if (!o)     begin ed = 1'b1; et = st; end
        else             em = (st == t);
        @(posedge clk);
        #1;
        checks++;
        if (match !== em || rd_drive !== ed || rd_tag !== et) begin
            errors++;
            $display("FAIL %s: match=%b drive=%b tag=%h expected match=%b drive=%b tag=%h",
                     req, match, rd_drive, rd_tag, em, ed, et);
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        step(0, 1, 1, 1, 0, 8'h00, "R1");
        step(0, 0, 0, 1, 3, 8'h5A, "R1");
        // R8: unwritten line reads and compares as zero
        step(1, 0, 1, 0, 5, 8'h00, "R8");
        step(1, 0, 1, 1, 5, 8'h00, "R8");
        step(1, 0, 1, 1, 5, 8'h3C, "R6");
        // R4 then R7: write followed immediately by compare
        step(1, 0, 0, 1, 5, 8'hA5, "R4");
        step(1, 0, 1, 1, 5, 8'hA5, "R7");
        step(1, 0, 1, 1, 5, 8'hA4, "R6");
        step(1, 0, 1, 0, 5, 8'h00, "R5");
        // R5: read forces match high despite mismatching tag
        step(1, 0, 1, 0, 5, 8'h0F, "R5");
        // R4: boundary lines
        step(1, 0, 0, 1, LW'((1 << LW) - 1), 8'hFF, "R4");
        step(1, 0, 0, 0, 0, 8'h01, "R4");
        step(1, 0, 1, 0, LW'((1 << LW) - 1), 8'h00, "R4");
        step(1, 0, 1, 1, 0, 8'h01, "R7");
        // R3: standby with write enable low changes nothing
        step(1, 1, 0, 1, 5, 8'h11, "R3");
        step(1, 1, 1, 1, 5, 8'hA5, "R3");
        step(1, 0, 1, 0, 5, 8'h00, "R3");
        // R9: compare leaves read data at zero
        step(1, 0, 1, 1, 0, 8'h01, "R9");
        // R2: write during reset is ignored, all lines cleared (R1)
        step(0, 0, 0, 1, 7, 8'h77, "R2");
        step(1, 0, 1, 0, 7, 8'h00, "R2");
        step(1, 0, 1, 0, 5, 8'h00, "R1");
        step(1, 0, 1, 1, 0, 8'h00, "R8");
        // Random mix over a narrow window; label by mode
        for (int i = 0; i < 600; i++) begin
            logic r, c, w, o;
            logic [LW-1:0] a;
            logic [TW-1:0] t;
            r = ($urandom % 50) != 0;
            c = ($urandom % 6) == 0;
            w = ($urandom % 3) != 0;
            o = ($urandom % 2) != 0;
            a = LW'($urandom % 4);
            t = TW'($urandom % 4);
            if (!r)      step(r, c, w, o, a, t, "R2");
            else if (c)  step(r, c, w, o, a, t, "R3");
            else if (!w) step(r, c, w, o, a, t, "R4");
            else if (!o) step(r, c, w, o, a, t, "R5");
            else         step(r, c, w, o, a, t, "R6");
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule